// File: doc/BRIEF.md
# Thread Interrupt Priority Presenter

This block holds the interrupt context of one hardware thread on a single signaling ring. It keeps a bitmap of pending thread-directed priorities, the processor's current priority threshold, the priority currently offered to the processor and a notification status byte. From these it drives the interrupt line to the core. Eight priority levels are used, and level 0 is the most favoured.

Four operations drive the block. A new interrupt arrives on a valid/ready port. It is either thread-directed or a group interrupt that has a group level. The other three operations are plain pulses: a threshold write, an accept that hands the presented interrupt to software, and a context push that merges a saved pending bitmap into the live one. A group interrupt is not stored in the bitmap. When it is displaced or cannot be shown, the block hands it back on a redistribute pulse so that a neighbouring distributor can place it elsewhere and it is not lost.

Top module: `thread_prio_presenter`

## Requirements
- R1: After reset the pending bitmap is 0, the threshold is 0xFF, the presented priority is 0xFF, the status byte is 0, irq is low and no redistribute or accept result is signaled.
- R2: Bit n of the pending bitmap means priority n is pending. The presented priority is the held group priority when a group interrupt is held. Otherwise it is the lowest set bit index if that index is below the threshold, and 0xFF if not.
- R3: A new interrupt is compared against the presented priority and not against the threshold. It is shown only if it is strictly more favoured. A thread-directed arrival always sets its bitmap bit, even when it is not shown.
- R4: A thread-directed arrival that is not more favoured than a held group interrupt sets its bitmap bit only. The presented priority and the status byte keep showing the group interrupt.
- R5: A held group interrupt that is displaced is signaled on redistribute for one cycle, with its priority, level and ring, on the cycle after the displacing operation. A displacing operation is a more favoured thread-directed arrival, a more favoured group arrival, or a push. A group arrival that cannot be shown is handed back the same way.
- R6: A threshold write loads the threshold. Afterwards the presented priority is never at or beyond it. If the shown interrupt is precluded, the status byte becomes 0 and irq falls. A precluded group interrupt is redistributed.
- R7: Status byte bits [7:6] give the presenting ring: 2'b10 is physical and 2'b01 is pool, and they are never both set. Bits [5:0] hold the group level, which is 0 for thread-directed interrupts. The ring of a shown thread-directed interrupt is the ring of the last thread-directed arrival that was shown. irq is high exactly when bits [7:6] are nonzero.
- R8: Accept returns the old status byte and presented priority on the accept result one cycle later. If something was presented, the threshold takes the accepted priority. The accepted bitmap bit is cleared, or a group interrupt is consumed, and the status byte reads 0 afterwards.
- R9: A push ORs the saved bitmap into the live bitmap, and the presented priority follows from the merged value.
- R10: Only one operation acts per cycle, in the order accept, threshold write, push, arrival. pres_ready is low while any of the other three is asserted. An arrival that is not accepted has no effect, and a lower-ranked pulse in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pres_valid | input | 1 | New interrupt offered |
| pres_ready | output | 1 | Arrival accepted this cycle |
| pres_prio | input | 3 | Priority of the arrival |
| pres_group | input | 1 | 1 for a group interrupt |
| pres_level | input | 6 | Group level, ignored for thread-directed arrivals |
| pres_pool | input | 1 | 1 when the pool ring presents, 0 when the physical ring presents |
| cppr_wr | input | 1 | Threshold write strobe |
| cppr_data | input | 8 | New threshold |
| accept | input | 1 | Accept strobe |
| ack_valid | output | 1 | Accept result valid |
| ack_nsr | output | 8 | Status byte before the accept |
| ack_pipr | output | 8 | Presented priority before the accept |
| push | input | 1 | Context push strobe |
| push_ipb | input | 8 | Saved pending bitmap to merge |
| ipb | output | 8 | Pending bitmap |
| cppr | output | 8 | Current threshold |
| pipr | output | 8 | Presented priority |
| nsr | output | 8 | Status byte |
| irq | output | 1 | Interrupt line to the core |
| redist_valid | output | 1 | Group interrupt handed back |
| redist_prio | output | 3 | Its priority |
| redist_level | output | 6 | Its group level |
| redist_pool | output | 1 | Its ring, 1 for pool |

## Verification
The bench offers an interrupt that is less favoured than the shown one while the threshold is fully open. A design that compares against the threshold would let it slip in and replace the presented priority. A thread-directed arrival is placed under a held group interrupt. A design that recomputes from the bitmap alone would show the lower priority. Group interrupts are then displaced in each way the block allows: by a thread-directed arrival, by another group arrival, by a push, by a threshold write, and by being unshowable on arrival. A design that drops any of them misses an expected redistribute item. Colliding pulses check that the port is back-pressured, and that a push lost to an accept leaves the bitmap untouched.

// File: rtl/tpp_pkg.sv
package tpp_pkg;
  // Ring field of the status byte; encodings use disjoint bits.
  typedef enum logic [1:0] {
    RING_NONE = 2'b00,
    RING_POOL = 2'b01,
    RING_PHYS = 2'b10
  } ring_e;

  function automatic ring_e ring_of(input logic pool);
    return pool ? RING_POOL : RING_PHYS;
  endfunction
endpackage

// File: rtl/tpp_lowbit.sv
module tpp_lowbit #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = i[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/tpp_view.sv
module tpp_view
  import tpp_pkg::*;
#(
  parameter int PW    = 3,
  parameter int LVL_W = 6,
  parameter int REG_W = 8,
  localparam int NSR_W = LVL_W + 2
) (
  input  logic             grp_vld,
  input  logic [PW-1:0]    grp_prio,
  input  logic [LVL_W-1:0] grp_lvl,
  input  logic             grp_pool,
  input  logic             vp_any,
  input  logic [PW-1:0]    vp_idx,
  input  logic             vp_pool,
  input  logic [REG_W-1:0] thr,
  output logic [REG_W-1:0] view_pipr,
  output logic [NSR_W-1:0] view_nsr,
  output logic             view_grp
);
  localparam logic [REG_W-1:0] EMPTY = '1;
  logic [REG_W-1:0] vp_wide, grp_wide;

  assign vp_wide  = {{(REG_W-PW){1'b0}}, vp_idx};
  assign grp_wide = {{(REG_W-PW){1'b0}}, grp_prio};

  always_comb begin
    view_grp  = 1'b0;
    view_pipr = EMPTY;
    view_nsr  = '0;
    if (grp_vld) begin
      view_grp  = 1'b1;
      view_pipr = grp_wide;
      view_nsr  = {ring_of(grp_pool), grp_lvl};
    end else if (vp_any && (vp_wide < thr)) begin
      view_pipr = vp_wide;
      view_nsr  = {ring_of(vp_pool), {LVL_W{1'b0}}};
    end
  end
endmodule

// File: rtl/thread_prio_presenter.sv
module thread_prio_presenter
  import tpp_pkg::*;
#(
  parameter int NPRIO = 8,
  parameter int LVL_W = 6,
  parameter int REG_W = 8,
  localparam int PW    = $clog2(NPRIO),
  localparam int NSR_W = LVL_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pres_valid,
  output logic             pres_ready,
  input  logic [PW-1:0]    pres_prio,
  input  logic             pres_group,
  input  logic [LVL_W-1:0] pres_level,
  input  logic             pres_pool,
  input  logic             cppr_wr,
  input  logic [REG_W-1:0] cppr_data,
  input  logic             accept,
  output logic             ack_valid,
  output logic [NSR_W-1:0] ack_nsr,
  output logic [REG_W-1:0] ack_pipr,
  input  logic             push,
  input  logic [NPRIO-1:0] push_ipb,
  output logic [NPRIO-1:0] ipb,
  output logic [REG_W-1:0] cppr,
  output logic [REG_W-1:0] pipr,
  output logic [NSR_W-1:0] nsr,
  output logic             irq,
  output logic             redist_valid,
  output logic [PW-1:0]    redist_prio,
  output logic [LVL_W-1:0] redist_level,
  output logic             redist_pool
);
  localparam logic [REG_W-1:0] EMPTY = '1;

  // Architectural state
  logic [NPRIO-1:0] ipb_q, ipb_n;
  logic [REG_W-1:0] cppr_q, cppr_n;
  logic             grp_vld_q, grp_vld_n;
  logic [PW-1:0]    grp_prio_q, grp_prio_n;
  logic [LVL_W-1:0] grp_lvl_q, grp_lvl_n;
  logic             grp_pool_q, grp_pool_n;
  logic             vp_pool_q, vp_pool_n;

  // Current view
  logic             vp_any, vp_any_n;
  logic [PW-1:0]    vp_idx, vp_idx_n;
  logic             view_grp;

  tpp_lowbit #(.N(NPRIO)) u_low_now (.vec(ipb_q), .any(vp_any),   .idx(vp_idx));
  tpp_lowbit #(.N(NPRIO)) u_low_nxt (.vec(ipb_n), .any(vp_any_n), .idx(vp_idx_n));

  tpp_view #(.PW(PW), .LVL_W(LVL_W), .REG_W(REG_W)) u_view (
    .grp_vld  (grp_vld_q),
    .grp_prio (grp_prio_q),
    .grp_lvl  (grp_lvl_q),
    .grp_pool (grp_pool_q),
    .vp_any   (vp_any),
    .vp_idx   (vp_idx),
    .vp_pool  (vp_pool_q),
    .thr      (cppr_q),
    .view_pipr(pipr),
    .view_nsr (nsr),
    .view_grp (view_grp)
  );

  assign ipb        = ipb_q;
  assign cppr       = cppr_q;
  assign irq        = (nsr[NSR_W-1 -: 2] != RING_NONE);
  assign pres_ready = !(accept || cppr_wr || push);

  logic             pres_fire;
  logic [REG_W-1:0] pres_wide;
  logic             take_new;
  logic             old_out, new_rej, disp;
  logic             rd_v;
  logic [PW-1:0]    rd_p;
  logic [LVL_W-1:0] rd_l;
  logic             rd_r;

  assign pres_fire = pres_valid && pres_ready;
  assign pres_wide = {{(REG_W-PW){1'b0}}, pres_prio};
  assign take_new  = pres_wide < pipr;   // compared against the shown priority

  // Group-stage: operation, then one common displacement check.
  logic             g1_vld;
  logic [PW-1:0]    g1_prio;
  logic [LVL_W-1:0] g1_lvl;
  logic             g1_pool;

  always_comb begin
    ipb_n     = ipb_q;
    cppr_n    = cppr_q;
    vp_pool_n = vp_pool_q;
    g1_vld    = grp_vld_q;
    g1_prio   = grp_prio_q;
    g1_lvl    = grp_lvl_q;
    g1_pool   = grp_pool_q;
    old_out   = 1'b0;
    new_rej   = 1'b0;
    if (accept) begin
      if (pipr != EMPTY) begin
        cppr_n = pipr;
        if (view_grp) g1_vld = 1'b0;
        else          ipb_n[vp_idx] = 1'b0;
      end
    end else if (cppr_wr) begin
      cppr_n = cppr_data;
    end else if (push) begin
      ipb_n = ipb_q | push_ipb;
    end else if (pres_fire) begin
      if (!pres_group) begin
        ipb_n[pres_prio] = 1'b1;
        if (take_new) vp_pool_n = pres_pool;
      end else if (take_new) begin
        old_out = grp_vld_q;
        g1_vld  = 1'b1;
        g1_prio = pres_prio;
        g1_lvl  = pres_level;
        g1_pool = pres_pool;
      end else begin
        new_rej = 1'b1;
      end
    end
  end

  always_comb begin
    disp = g1_vld &&
           ((vp_any_n && (vp_idx_n < g1_prio)) ||
            ({{(REG_W-PW){1'b0}}, g1_prio} >= cppr_n));
    grp_vld_n  = g1_vld && !disp;
    grp_prio_n = g1_prio;
    grp_lvl_n  = g1_lvl;
    grp_pool_n = g1_pool;
    rd_v = disp || old_out || new_rej;
    rd_p = g1_prio;
    rd_l = g1_lvl;
    rd_r = g1_pool;
    if (!disp && old_out) begin
      rd_p = grp_prio_q;
      rd_l = grp_lvl_q;
      rd_r = grp_pool_q;
    end else if (!disp && new_rej) begin
      rd_p = pres_prio;
      rd_l = pres_level;
      rd_r = pres_pool;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ipb_q        <= '0;
      cppr_q       <= EMPTY;
      grp_vld_q    <= 1'b0;
      grp_prio_q   <= '0;
      grp_lvl_q    <= '0;
      grp_pool_q   <= 1'b0;
      vp_pool_q    <= 1'b0;
      redist_valid <= 1'b0;
      redist_prio  <= '0;
      redist_level <= '0;
      redist_pool  <= 1'b0;
      ack_valid    <= 1'b0;
      ack_nsr      <= '0;
      ack_pipr     <= EMPTY;
    end else begin
      ipb_q        <= ipb_n;
      cppr_q       <= cppr_n;
      grp_vld_q    <= grp_vld_n;
      grp_prio_q   <= grp_prio_n;
      grp_lvl_q    <= grp_lvl_n;
      grp_pool_q   <= grp_pool_n;
      vp_pool_q    <= vp_pool_n;
      redist_valid <= rd_v;
      redist_prio  <= rd_p;
      redist_level <= rd_l;
      redist_pool  <= rd_r;
      ack_valid    <= accept;
      ack_nsr      <= nsr;
      ack_pipr     <= pipr;
    end
  end

  // ---------------- assertions ----------------
  assert_pipr_below_thr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pipr != EMPTY) |-> (pipr < cppr));

  assert_ring_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(nsr[NSR_W-1 -: 2]));

  assert_accept_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (nsr == '0) && !irq);

  assert_thr_loaded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cppr_wr && !accept) |=> (cppr == $past(cppr_data)));

  assert_push_merge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !accept && !cppr_wr) |=> (ipb == ($past(ipb) | $past(push_ipb))));

  assert_vp_under_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pres_fire && !pres_group && view_grp && !take_new) |=> $stable(nsr) && $stable(pipr));

  assert_group_displaced_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pres_fire && !pres_group && view_grp && take_new) |=> redist_valid);

  assert_no_slip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pres_fire && !take_new) |=> $stable(pipr));

  assert_port_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept || cppr_wr || push) |-> !pres_ready);
endmodule

// File: tb/tb_thread_prio_presenter.sv
module tb_thread_prio_presenter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pres_valid = 1'b0, pres_group = 1'b0, pres_pool = 1'b0;
  logic [2:0] pres_prio = '0;
  logic [5:0] pres_level = '0;
  logic       cppr_wr = 1'b0, accept = 1'b0, push = 1'b0;
  logic [7:0] cppr_data = '0, push_ipb = '0;
  logic       pres_ready, ack_valid, irq, redist_valid, redist_pool;
  logic [7:0] ack_nsr, ack_pipr, ipb, cppr, pipr, nsr;
  logic [2:0] redist_prio;
  logic [5:0] redist_level;

  int total = 0, bad = 0;
  logic [9:0]  rd_q[$];   // {prio, level, pool}
  logic [15:0] ack_q[$];  // {nsr, pipr}

  always #4 clk = ~clk;

  thread_prio_presenter dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic state(input string req, input logic [7:0] e_ipb, input logic [7:0] e_cppr,
                       input logic [7:0] e_pipr, input logic [7:0] e_nsr);
    chk({req, " ipb"}, ipb, e_ipb);
    chk({req, " cppr"}, cppr, e_cppr);
    chk({req, " pipr"}, pipr, e_pipr);
    chk({req, " nsr"}, nsr, e_nsr);
    chk({req, " irq"}, irq, e_nsr[7:6] != 2'b00);
  endtask

  task automatic step();
    @(negedge clk);
    pres_valid = 0; cppr_wr = 0; accept = 0; push = 0;
  endtask

  task automatic give(input logic [2:0] p, input logic g, input logic [5:0] l, input logic pl);
    pres_valid = 1; pres_prio = p; pres_group = g; pres_level = l; pres_pool = pl;
    step();
  endtask

  task automatic wr_thr(input logic [7:0] v);
    cppr_wr = 1; cppr_data = v; step();
  endtask

  task automatic do_accept(input logic [7:0] e_nsr, input logic [7:0] e_pipr);
    ack_q.push_back({e_nsr, e_pipr});
    accept = 1; step();
  endtask

  task automatic do_push(input logic [7:0] v);
    push = 1; push_ipb = v; step();
  endtask

  // Monitor: pops expected items as the design produces them.
  always @(negedge clk) begin
    if (rst_n && redist_valid) begin
      total++;
      if (rd_q.size() == 0) begin
        bad++;
        $display("FAIL R5 unexpected redistribute actual=%0h expected=none",
                 {redist_prio, redist_level, redist_pool});
      end else begin
        logic [9:0] e;
        e = rd_q.pop_front();
        if ({redist_prio, redist_level, redist_pool} !== e) begin
          bad++;
          $display("FAIL R5 redistribute actual=%0h expected=%0h",
                   {redist_prio, redist_level, redist_pool}, e);
        end
      end
    end
    if (rst_n && ack_valid) begin
      total++;
      if (ack_q.size() == 0) begin
        bad++;
        $display("FAIL R8 unexpected accept result actual=%0h expected=none", {ack_nsr, ack_pipr});
      end else begin
        logic [15:0] e;
        e = ack_q.pop_front();
        if ({ack_nsr, ack_pipr} !== e) begin
          bad++;
          $display("FAIL R8 accept result actual=%0h expected=%0h", {ack_nsr, ack_pipr}, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 redist idle", redist_valid, 0);
    chk("R1 ack idle", ack_valid, 0);
    state("R1 reset", 8'h00, 8'hFF, 8'hFF, 8'h00);

    give(3'd5, 0, 0, 0);  state("R2 R7 vp phys", 8'h20, 8'hFF, 8'h05, 8'h80);
    give(3'd6, 0, 0, 1);  state("R3 less favoured", 8'h60, 8'hFF, 8'h05, 8'h80);
    give(3'd3, 0, 0, 1);  state("R3 R7 more favoured pool", 8'h68, 8'hFF, 8'h03, 8'h40);
    do_accept(8'h40, 8'h03); state("R8 accept", 8'h60, 8'h03, 8'hFF, 8'h00);
    wr_thr(8'hFF);        state("R6 R2 reopen", 8'h60, 8'hFF, 8'h05, 8'h40);
    do_accept(8'h40, 8'h05); state("R8 accept2", 8'h40, 8'h05, 8'hFF, 8'h00);
    wr_thr(8'hFF);        state("R2 reopen2", 8'h40, 8'hFF, 8'h06, 8'h40);
    give(3'd2, 1, 6'd3, 0); state("R2 R7 group", 8'h40, 8'hFF, 8'h02, 8'h83);
    give(3'd4, 0, 0, 0);  state("R4 vp under group", 8'h50, 8'hFF, 8'h02, 8'h83);
    rd_q.push_back({3'd2, 6'd3, 1'b0});
    give(3'd1, 0, 0, 1);  state("R5 vp displaces group", 8'h52, 8'hFF, 8'h01, 8'h40);
    rd_q.push_back({3'd1, 6'd5, 1'b1});
    give(3'd1, 1, 6'd5, 1); state("R3 R5 equal group rejected", 8'h52, 8'hFF, 8'h01, 8'h40);
    do_accept(8'h40, 8'h01); state("R8 accept3", 8'h50, 8'h01, 8'hFF, 8'h00);
    wr_thr(8'h07);        state("R6 thr 7", 8'h50, 8'h07, 8'h04, 8'h40);
    give(3'd0, 1, 6'd2, 1); state("R7 group pool", 8'h50, 8'h07, 8'h00, 8'h42);
    rd_q.push_back({3'd0, 6'd2, 1'b1});
    wr_thr(8'h00);        state("R6 precluded group", 8'h50, 8'h00, 8'hFF, 8'h00);
    do_push(8'h09);       state("R9 push masked", 8'h59, 8'h00, 8'hFF, 8'h00);
    wr_thr(8'hFF);        state("R9 merged view", 8'h59, 8'hFF, 8'h00, 8'h40);

    // R10: collision of accept, push and an arrival
    ack_q.push_back({8'h40, 8'h00});
    accept = 1; push = 1; push_ipb = 8'h80;
    pres_valid = 1; pres_prio = 3'd0; pres_group = 1; pres_level = 6'd1; pres_pool = 0;
    #1 chk("R10 ready low", pres_ready, 0);
    step();               state("R10 accept wins", 8'h58, 8'h00, 8'hFF, 8'h00);

    rd_q.push_back({3'd2, 6'd7, 1'b0});
    give(3'd2, 1, 6'd7, 0); state("R5 R6 group beyond thr", 8'h58, 8'h00, 8'hFF, 8'h00);
    wr_thr(8'hFF);        state("R2 reopen3", 8'h58, 8'hFF, 8'h03, 8'h40);
    give(3'd2, 1, 6'd1, 0); state("R5 group a", 8'h58, 8'hFF, 8'h02, 8'h81);
    rd_q.push_back({3'd2, 6'd1, 1'b0});
    give(3'd1, 1, 6'd4, 1); state("R5 group on group", 8'h58, 8'hFF, 8'h01, 8'h44);
    rd_q.push_back({3'd1, 6'd4, 1'b1});
    do_push(8'h01);       state("R5 R9 push displaces", 8'h59, 8'hFF, 8'h00, 8'h40);

    step(); step();
    chk("R5 redistribute queue drained", rd_q.size(), 0);
    chk("R8 accept queue drained", ack_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule